// File: doc/BRIEF.md
# SDRAM Command Mode Translator

This block turns host memory-cycle requests into commands on the SDRAM command pins. A small 8-bit control register, written and read over a plain configuration port, sets how the translation works. In normal operation a host cycle becomes a row activate, one column command per cache line, and a final precharge of all banks. The block also marks each clock in which a data beat is on the memory bus.

The memory has to be detected and initialised before normal use. For this, a 3-bit operation field in the register makes every host cycle become exactly one raw SDRAM command: a NOP, an all-bank precharge, a mode-register load whose value is the host address, or a CAS-before-RAS refresh. Firmware can then bring up the memory using ordinary host reads and writes.

A bank-interleave option sends consecutive cache lines of a burst to rotating banks, across two or four banks. This removes the three-clock gap between lines. Configuration is captured when a host cycle is accepted, so a register write made during a cycle only affects later cycles.

Top module: `sdram_cmd_xlat`

## Requirements
- R1: After reset the control register reads 0x00, the command pins {cs_n,ras_n,cas_n,we_n} show deselect 1111, and host_ack and data_beat are low. The pins return to deselect whenever no host cycle is in progress.
- R2: A configuration write stores the data with bit 4 forced to 0, so bit 4 always reads 0. Without a write, the value read back does not change.
- R3: Operation codes 101, 110 and 111 in bits 2:0 read back exactly as written, and host cycles then behave as in normal mode (code 000).
- R4: With code 001, a host cycle produces a single NOP (0111) one clock after acceptance. host_ack follows one clock later, and no data beat occurs. The same one-command-then-acknowledge timing applies to codes 010, 011 and 100.
- R5: With code 010, the command for a host cycle is precharge (0010) with sd_ma[10] high, which closes all banks.
- R6: With code 011, the command is mode load (0000), and sd_ma carries host_addr[11:0].
- R7: With code 100, the command is CAS-before-RAS refresh (0001).
- R8: In normal mode the address splits into row host_addr[21:10], bank host_addr[9:8] and column host_addr[7:0]. An activate (0011) with the row on sd_ma is issued one clock after acceptance. Line k gets its read (0101) or write (0100) 6 clocks after acceptance plus k times the line spacing, with column + 4k and sd_ma[10] low. With interleave off (bit 5 = 0), the spacing is 6. A three-line read at CAS latency 2 then gives beats 8-1-1-1-3-1-1-1-3-1-1-1 clocks after acceptance.
- R9: With bit 5 = 1, the line spacing is 4, giving beats 8-1-1-1-1-1-1-1-1-1-1-1. Line k uses bank (base + k) mod 4 when bit 7 = 1. When bit 7 = 0, it uses the base bank with its low bit toggled on odd k. Each further bank a burst needs is activated on the clocks right after the first activate.
- R10: Bit 3 selects CAS latency: 0 means 2 clocks, 1 means 3 clocks. The four read beats of a line fall that many clocks after its read command.
- R11: For writes, the beats coincide with the write commands. With bit 6 = 1, one write command covers the four beats of a line. With bit 6 = 0, each beat gets its own write command, with the column stepping by one.
- R12: A register write made while a host cycle is in progress reads back at once but does not alter that cycle. The next accepted cycle uses it.
- R13: A normal-mode cycle ends one clock after its last data beat with a precharge (0010, sd_ma[10] high) together with a one-clock host_ack pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| host_req | input | 1 | Host memory cycle request, held until host_ack |
| host_write | input | 1 | 1 = write cycle, 0 = read cycle |
| host_lines | input | 2 | Cache lines in the burst (1 to 3; 0 treated as 1) |
| host_addr | input | 22 | Host address: row, bank, column |
| host_ack | output | 1 | One-clock end-of-cycle acknowledge |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ma | output | 12 | SDRAM multiplexed address |
| sd_ba | output | 2 | SDRAM bank address |
| data_beat | output | 1 | High in each clock a data beat is on the bus |

## Verification
The assertions assume the host keeps host_req high until it sees host_ack and drops it before the next edge. They also assume host_lines stays within 1 to 3. The bench drives each request on a falling edge, waits for the acknowledge, and releases the request in the middle of the acknowledge clock, so the idle-to-busy handshake stays within those assumptions. Configuration writes are issued only between cycles, except in the one scenario that moves the register in the middle of a burst to exercise the capture-at-acceptance rule.

// File: rtl/sdram_cmd_xlat.sv
module sdram_cmd_xlat #(
  parameter int ROW_W     = 12,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 8,
  parameter int MA_W      = 12,
  parameter int T_RCD     = 5,
  parameter int MAX_LINES = 3,
  parameter int BEATS     = 4,
  parameter int GAP_NI    = 6,
  parameter int GAP_IL    = 4,
  localparam int ADDR_W   = ROW_W + BANK_W + COL_W,
  localparam int LN_W     = $clog2(MAX_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              host_req,
  input  logic              host_write,
  input  logic [LN_W-1:0]   host_lines,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              host_ack,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [MA_W-1:0]   sd_ma,
  output logic [BANK_W-1:0] sd_ba,
  output logic              data_beat
);
  localparam int CMD_T = 1 + T_RCD;
  localparam int T_MAX = CMD_T + (MAX_LINES - 1) * GAP_NI + 3 + BEATS + 2;
  localparam int TW    = $clog2(T_MAX + 1);

  localparam logic [3:0] C_DESEL = 4'b1111, C_NOP = 4'b0111, C_ACT = 4'b0011,
                         C_RD = 4'b0101, C_WR = 4'b0100, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_MRS = 4'b0000;

  logic [7:0]        cfg_q;
  logic              busy;
  logic [TW-1:0]     t;
  logic              s_sp, s_wr, s_bw, s_il, s_il4, s_cl3;
  logic [2:0]        s_op;
  logic [LN_W-1:0]   s_lines;
  logic [ROW_W-1:0]  s_row;
  logic [BANK_W-1:0] s_bank;
  logic [COL_W-1:0]  s_col;
  logic [MA_W-1:0]   s_mra;
  logic [3:0]        cmd;
  logic [MA_W-1:0]   ma;
  logic [BANK_W-1:0] ba;
  logic              beat;
  int                pre_t;

  wire [2:0] op     = cfg_q[2:0];
  wire       op_sp  = (op != 3'd0) && (op <= 3'd4);
  wire       accept = host_req && !busy;

  assign cfg_rdata = cfg_q;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_ma     = ma;
  assign sd_ba     = ba;
  assign data_beat = beat;
  assign host_ack  = busy && (s_sp ? (t == TW'(2)) : (int'(t) == pre_t));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; busy <= 1'b0; t <= '0;
      s_sp <= 1'b0; s_wr <= 1'b0; s_bw <= 1'b0; s_il <= 1'b0; s_il4 <= 1'b0; s_cl3 <= 1'b0;
      s_op <= '0; s_lines <= '0; s_row <= '0; s_bank <= '0; s_col <= '0; s_mra <= '0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_wdata & 8'hEF;
      if (accept) begin
        busy    <= 1'b1;
        t       <= TW'(1);
        s_sp    <= op_sp;
        s_op    <= op;
        s_wr    <= host_write;
        s_bw    <= cfg_q[6];
        s_il    <= cfg_q[5];
        s_il4   <= cfg_q[7];
        s_cl3   <= cfg_q[3];
        s_lines <= (host_lines == '0) ? LN_W'(1) : host_lines;
        s_row   <= host_addr[ADDR_W-1 -: ROW_W];
        s_bank  <= host_addr[COL_W +: BANK_W];
        s_col   <= host_addr[COL_W-1:0];
        s_mra   <= host_addr[MA_W-1:0];
      end else if (busy) begin
        if (host_ack) begin
          busy <= 1'b0;
          t    <= '0;
        end else begin
          t <= t + 1'b1;
        end
      end
    end
  end

  always_comb begin
    int tt, gap, cl, nb, st;
    logic [BANK_W-1:0] bk;
    tt    = int'(t);
    gap   = s_il ? GAP_IL : GAP_NI;
    cl    = s_cl3 ? 3 : 2;
    nb    = s_il4 ? 4 : 2;
    pre_t = CMD_T + (int'(s_lines) - 1) * gap + (s_wr ? 0 : cl) + BEATS;
    cmd   = busy ? C_NOP : C_DESEL;
    ma    = '0;
    ba    = '0;
    beat  = 1'b0;
    if (busy && s_sp) begin
      if (tt == 1) begin
        case (s_op)
          3'd2:    begin cmd = C_PRE; ma[10] = 1'b1; end
          3'd3:    begin cmd = C_MRS; ma = s_mra; end
          3'd4:    cmd = C_REF;
          default: cmd = C_NOP;
        endcase
      end
    end else if (busy) begin
      if (tt == 1) begin
        cmd = C_ACT; ma = MA_W'(s_row); ba = s_bank;
      end
      for (int j = 1; j < MAX_LINES; j++) begin
        bk = s_il4 ? s_bank + BANK_W'(j) : s_bank ^ BANK_W'(j % 2);
        if (s_il && j < int'(s_lines) && j < nb && tt == 1 + j) begin
          cmd = C_ACT; ma = MA_W'(s_row); ba = bk;
        end
      end
      for (int k = 0; k < MAX_LINES; k++) begin
        st = CMD_T + k * gap;
        bk = !s_il ? s_bank : s_il4 ? s_bank + BANK_W'(k) : s_bank ^ BANK_W'(k % 2);
        if (k < int'(s_lines)) begin
          if (s_wr && tt >= st && tt < st + BEATS) begin
            beat = 1'b1;
            if (!s_bw || tt == st) begin
              cmd = C_WR; ba = bk;
              ma  = MA_W'(s_col + COL_W'(k * BEATS + (s_bw ? 0 : tt - st)));
            end
          end
          if (!s_wr && tt == st) begin
            cmd = C_RD; ba = bk; ma = MA_W'(s_col + COL_W'(k * BEATS));
          end
          if (!s_wr && tt >= st + cl && tt < st + cl + BEATS) beat = 1'b1;
        end
      end
      if (tt == pre_t) begin
        cmd = C_PRE; ma = '0; ma[10] = 1'b1; ba = '0;
      end
    end
  end

  p_idle_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd == C_DESEL && !data_beat));
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata));
  p_special_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && s_sp) |=> host_ack);
  p_special_nobeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && s_sp) |-> !data_beat);
  p_pre_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> sd_ma[10]);
  p_cl2_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD && !s_cl3) |-> ##2 data_beat);
  p_cl3_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD && s_cl3) |-> ##3 data_beat);
  p_ack_pre_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && !s_sp) |-> (cmd == C_PRE && sd_ma[10]));
  p_ack_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);
endmodule

// File: tb/test_sdram_cmd_xlat.sv
`timescale 1ns/1ps
module test_sdram_cmd_xlat;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_wr = 1'b0; logic [7:0] cfg_wdata = '0; logic [7:0] cfg_rdata;
  logic host_req = 1'b0, host_write = 1'b0; logic [1:0] host_lines = 2'd1;
  logic [21:0] host_addr = '0;
  logic host_ack, cs_n, ras_n, cas_n, we_n, beat;
  logic [11:0] ma; logic [1:0] ba;

  sdram_cmd_xlat i_sdram_cmd_xlat (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .host_req(host_req), .host_write(host_write), .host_lines(host_lines), .host_addr(host_addr),
    .host_ack(host_ack), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ma(ma), .sd_ba(ba), .data_beat(beat));

  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000, DES = 4'b1111;

  typedef struct packed { logic [3:0] cmd; logic [11:0] ma; logic [1:0] ba; logic bt; logic ack; } exp_t;
  exp_t q[$]; string qr[$]; int beat_t[$];
  int tcyc = 0, n_chk = 0, n_fail = 0;
  logic [7:0] m_cfg = 8'h00;
  wire [3:0] cmd = {cs_n, ras_n, cas_n, we_n};

  task automatic chk(input string r, input bit ok, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  function automatic exp_t mk(logic [3:0] c, logic [11:0] m, logic [1:0] b, logic bt, logic ak);
    exp_t e; e.cmd = c; e.ma = m; e.ba = b; e.bt = bt; e.ack = ak; return e;
  endfunction

  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e; exp_t a; string r;
      e = q.pop_front(); r = qr.pop_front(); tcyc++;
      a = mk(cmd, ma, ba, beat, host_ack);
      chk($sformatf("%s cycle %0d", r, tcyc), a == e, 32'(a), 32'(e));
      if (beat) beat_t.push_back(tcyc);
    end
  end

  task automatic cfg_write(input logic [7:0] d, input string r);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
    m_cfg = d & 8'hEF;
    chk({r, " readback"}, cfg_rdata == m_cfg, 32'(cfg_rdata), 32'(m_cfg));
  endtask

  function automatic logic [1:0] bank_of(logic [1:0] b0, int k, bit il, bit il4);
    if (!il) return b0;
    if (il4) return 2'(b0 + 2'(k));
    return b0 ^ 2'(k & 1);
  endfunction

  task automatic txn(input string tag, input bit wr, input int lines, input logic [21:0] addr,
                     input bit mid, input logic [7:0] mid_val);
    exp_t a [0:48];
    int L, cl, gap, nb, s, cyc;
    logic [2:0] mode; logic [7:0] c; logic [1:0] bk;
    mode = m_cfg[2:0];
    if (mode >= 3'd1 && mode <= 3'd4) begin
      L = 2;
      case (mode)
        3'd1: a[1] = mk(NOP, 12'h000, 2'd0, 1'b0, 1'b0);
        3'd2: a[1] = mk(PRE, 12'h400, 2'd0, 1'b0, 1'b0);
        3'd3: a[1] = mk(MRS, addr[11:0], 2'd0, 1'b0, 1'b0);
        default: a[1] = mk(REF, 12'h000, 2'd0, 1'b0, 1'b0);
      endcase
      a[2] = mk(NOP, 12'h000, 2'd0, 1'b0, 1'b1);
    end else begin
      cl  = m_cfg[3] ? 3 : 2;
      gap = m_cfg[5] ? 4 : 6;
      nb  = m_cfg[7] ? 4 : 2;
      L   = 6 + (lines - 1) * gap + (wr ? 0 : cl) + 4;
      for (int i = 1; i <= L; i++) a[i] = mk(NOP, 12'h000, 2'd0, 1'b0, 1'b0);
      a[1] = mk(ACT, addr[21:10], addr[9:8], 1'b0, 1'b0);
      if (m_cfg[5])
        for (int j = 1; j < lines && j < nb; j++)
          a[1 + j] = mk(ACT, addr[21:10], bank_of(addr[9:8], j, 1'b1, m_cfg[7]), 1'b0, 1'b0);
      for (int k = 0; k < lines; k++) begin
        s = 6 + k * gap; bk = bank_of(addr[9:8], k, m_cfg[5], m_cfg[7]);
        c = addr[7:0] + 8'(4 * k);
        if (!wr) a[s] = mk(RD, {4'h0, c}, bk, 1'b0, 1'b0);
        else
          for (int i = 0; i < 4; i++)
            if (!m_cfg[6]) a[s + i] = mk(WR, {4'h0, c + 8'(i)}, bk, 1'b1, 1'b0);
            else if (i == 0) a[s] = mk(WR, {4'h0, c}, bk, 1'b1, 1'b0);
            else a[s + i].bt = 1'b1;
      end
      if (!wr)
        for (int k = 0; k < lines; k++)
          for (int i = 0; i < 4; i++) a[6 + k * gap + cl + i].bt = 1'b1;
      a[L] = mk(PRE, 12'h400, 2'd0, 1'b0, 1'b1);
    end
    @(negedge clk);
    host_req = 1'b1; host_write = wr; host_lines = 2'(lines); host_addr = addr;
    @(posedge clk); #1;
    beat_t.delete(); tcyc = 0;
    for (int i = 1; i <= L; i++) begin q.push_back(a[i]); qr.push_back(tag); end
    cyc = 0;
    while (1) begin
      @(negedge clk); #1; cyc++;
      if (mid && cyc == 3) begin cfg_wr = 1'b1; cfg_wdata = mid_val; end
      if (mid && cyc == 4) begin
        cfg_wr = 1'b0; m_cfg = mid_val & 8'hEF;
        chk("R12 mid-cycle readback", cfg_rdata == m_cfg, 32'(cfg_rdata), 32'(m_cfg));
      end
      if (q.size() == 0) break;
    end
    host_req = 1'b0;
    @(negedge clk);
    chk({tag, " R1 idle after ack"}, cmd == DES && !host_ack && !beat,
        32'({cmd, host_ack, beat}), 32'({DES, 2'b00}));
  endtask

  task automatic chk_gaps(input string tag, input bit il, input int first);
    chk({tag, " beat count"}, beat_t.size() == 12, 32'(beat_t.size()), 32'd12);
    if (beat_t.size() == 12) begin
      chk({tag, " first beat"}, beat_t[0] == first, 32'(beat_t[0]), 32'(first));
      for (int i = 1; i < 12; i++) begin
        int g; g = (!il && i % 4 == 0) ? 3 : 1;
        chk($sformatf("%s gap %0d", tag, i), beat_t[i] - beat_t[i-1] == g,
            32'(beat_t[i] - beat_t[i-1]), 32'(g));
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cfg", cfg_rdata == 8'h00, 32'(cfg_rdata), 32'h0);
    chk("R1 reset pins", cmd == DES && !host_ack && !beat, 32'({cmd, host_ack, beat}), 32'({DES, 2'b00}));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins after reset", cmd == DES, 32'(cmd), 32'(DES));
    cfg_write(8'hFF, "R2 bit4 dropped");
    cfg_write(8'h10, "R2 bit4 only");
    cfg_write(8'h15, "R3 code 101");
    cfg_write(8'h07, "R3 code 111");
    cfg_write(8'h06, "R3 code 110");
    txn("R3 reserved as normal", 1'b0, 1, 22'h0A5_123, 1'b0, 8'h0);

    cfg_write(8'h00, "R8 cfg");
    txn("R8 R13 read no interleave", 1'b0, 3, 22'h123_210, 1'b0, 8'h0);
    chk_gaps("R8 pattern", 1'b0, 8);
    txn("R8 single line", 1'b0, 1, 22'h3FF_3F0, 1'b0, 8'h0);
    cfg_write(8'h08, "R10 cfg");
    txn("R10 CL3 read", 1'b0, 3, 22'h011_140, 1'b0, 8'h0);
    chk_gaps("R10 pattern", 1'b0, 9);
    cfg_write(8'h20, "R9 cfg");
    txn("R9 two-bank interleave", 1'b0, 3, 22'h2A5_120, 1'b0, 8'h0);
    chk_gaps("R9 pattern", 1'b1, 8);
    cfg_write(8'hA0, "R9 cfg4");
    txn("R9 four-bank interleave", 1'b0, 3, 22'h155_330, 1'b0, 8'h0);
    cfg_write(8'hA8, "R9 cfg4 CL3");
    txn("R9 R10 four-bank CL3", 1'b0, 2, 22'h0F0_200, 1'b0, 8'h0);
    cfg_write(8'h80, "R9 bit7 alone");
    txn("R9 bit7 without enable", 1'b0, 2, 22'h0F0_100, 1'b0, 8'h0);

    cfg_write(8'h40, "R11 cfg");
    txn("R11 burst write", 1'b1, 2, 22'h321_080, 1'b0, 8'h0);
    cfg_write(8'h00, "R11 cfg single");
    txn("R11 single-beat write", 1'b1, 1, 22'h321_0F0, 1'b0, 8'h0);
    cfg_write(8'h60, "R11 cfg il");
    txn("R11 interleaved burst write", 1'b1, 3, 22'h001_310, 1'b0, 8'h0);

    cfg_write(8'h01, "R4 cfg");
    txn("R4 NOP mode", 1'b0, 3, 22'h123_456, 1'b0, 8'h0);
    txn("R4 NOP mode write", 1'b1, 2, 22'h000_001, 1'b0, 8'h0);
    cfg_write(8'h22, "R5 cfg");
    txn("R5 precharge mode", 1'b0, 2, 22'h3AB_CDE, 1'b0, 8'h0);
    cfg_write(8'h0B, "R6 cfg");
    txn("R6 mode load", 1'b0, 1, 22'h2AB_832, 1'b0, 8'h0);
    txn("R6 mode load write", 1'b1, 1, 22'h000_021, 1'b0, 8'h0);
    cfg_write(8'h04, "R7 cfg");
    txn("R7 refresh", 1'b0, 3, 22'h111_111, 1'b0, 8'h0);

    cfg_write(8'h00, "R12 cfg");
    txn("R12 in-flight keeps old cfg", 1'b0, 3, 22'h222_000, 1'b1, 8'h28);
    chk_gaps("R12 old pattern", 1'b0, 8);
    txn("R12 next uses new cfg", 1'b0, 3, 22'h222_000, 1'b0, 8'h0);
    chk_gaps("R12 new pattern", 1'b1, 9);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule